// File: doc/BRIEF.md
# GPIO Interrupt Sense and Pending Unit

This unit watches 32 already-synchronized GPIO input levels and turns them into interrupt requests. Each pin has its own programmable sense mode (rising edge, falling edge, both edges, level high or level low). A per-pin detect enable decides whether a pin may record an event at all. Recorded events sit in a pending register that software clears by writing ones. A separate unmask state, changed through a set strobe address and a clear strobe address, selects which pending bits reach the two request outputs. One output covers pins 0 to 15 and the other covers pins 16 to 31.

Software reaches the unit through a simple register port: a write strobe with byte address and data, and a read address whose data comes back one clock later. Edges are found by comparing each pin with its own value from one clock earlier. Level modes keep re-asserting the pending bit for as long as the level holds, so a level source must be quieted before its pending bit can be cleared.

Top module: `gpio_irq_sense`

## Requirements
- R1: After a synchronous reset, every pin is masked, detect-disabled and not pending, every sense field is 0, both request outputs are 0 and read data is 0.
- R2: Pin n's 4-bit sense field lies in bits 4*(n%8)+3 : 4*(n%8) of the configuration register at byte address 0x40 + 4*(n/8). The low three bits select the mode: 0 rising edge, 1 falling edge, 2 level high, 3 level low, 4 both edges. Codes 5 to 7 detect nothing. Bit 3 is stored and read back but does not change detection.
- R3: In rising and falling modes, a pending bit is set only in the cycle after the matching transition, where the transition is found against the pin's value one clock earlier. A held level sets nothing further.
- R4: In both-edges mode, either transition sets the pending bit.
- R5: In level modes, the pending bit is set on every cycle the active level is present, so a clear written while the level is still present has no lasting effect.
- R6: The detect-enable register at 0x14 is read/write. A pin whose enable bit is 0 sets no pending bit, whatever its input does.
- R7: Writing a 1 to bit n at 0x28 clears pending bit n. If a set event for that pin falls in the same cycle, the bit stays set.
- R8: Writing a 1 to bit n at 0x18 unmasks pin n, and writing a 1 at 0x1C masks it. Zero bits leave the state unchanged. Reading 0x18 returns the unmask state.
- R9: Reading 0x20 returns the raw pending bits, and reading 0x24 returns the pending bits ANDed with the unmask bits.
- R10: irq_lo is the OR of masked status bits 15:0 and irq_hi is the OR of bits 31:16. Both are registered, so they follow a pending change one clock later.
- R11: Read data is registered: it reflects the address presented at the previous clock edge. Unmapped addresses, including 0x1C, read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 32 | Synchronized GPIO input levels |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_lo | output | 1 | Request for pins 0 to 15 |
| irq_hi | output | 1 | Request for pins 16 to 31 |

## Verification
The bench targets the race between a write-one clear and a detected event on the same pin. A design where the clear wins would lose that edge and show bit 3 clear after the collision. It also clears a level-low pin while the level still holds. A design that treats levels as edges would let that bit fall, and a design that sets on levels only once would never re-arm it. Further cases cover a falling-mode pin that sees a rising edge, a disabled pin that toggles, and a pin programmed with code 5. Each of these must leave the raw pending word unchanged, and an encoding mix-up shows as a stray bit there. The one-cycle delay of the request lines is sampled on both sides of the edge, and a field written with its top flag set must still detect as level high.

// File: rtl/gis_pkg.sv
`timescale 1ns/1ps
package gis_pkg;
  // register byte offsets (software-visible contract)
  localparam logic [7:0] OFS_DET_EN = 8'h14;
  localparam logic [7:0] OFS_UNMASK = 8'h18;
  localparam logic [7:0] OFS_MASK   = 8'h1C;
  localparam logic [7:0] OFS_RAW    = 8'h20;
  localparam logic [7:0] OFS_MASKED = 8'h24;
  localparam logic [7:0] OFS_CLEAR  = 8'h28;
  localparam logic [7:0] OFS_SENSE0 = 8'h40;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SNS_RISE = 3'd0,
    SNS_FALL = 3'd1,
    SNS_HIGH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_BOTH = 3'd4
  } sense_e;
endpackage

// File: rtl/gis_sense_cfg.sv
`timescale 1ns/1ps
// Bank of sense configuration registers, FIELD_W bits per pin (R2).
module gis_sense_cfg #(
  parameter int NPINS   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int FIELD_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wen,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NPINS*FIELD_W-1:0]   fields
);
  localparam int PER_REG = DATA_W / FIELD_W;
  localparam int NREG    = (NPINS + PER_REG - 1) / PER_REG;

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (wen && addr == ADDR_W'(int'(gis_pkg::OFS_SENSE0) + 4 * r))
          q <= wdata;
      end
      assign fields[r*DATA_W +: DATA_W] = q;
    end
  endgenerate
endmodule

// File: rtl/gis_edge_level.sv
`timescale 1ns/1ps
// Per-pin event detector: edge modes compare against a one-cycle-old copy (R3, R4),
// level modes fire every cycle the level holds (R5), gated by detect enable (R6).
module gis_edge_level #(
  parameter int NPINS = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NPINS-1:0]                 pin_lvl,
  input  logic [NPINS*gis_pkg::MODE_W-1:0] modes,
  input  logic [NPINS-1:0]                 det_en,
  output logic [NPINS-1:0]                 hit
);
  import gis_pkg::*;

  logic [NPINS-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_lvl;
  end

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic [MODE_W-1:0] m;
      logic cur, prv, act;
      assign m   = modes[i*MODE_W +: MODE_W];
      assign cur = pin_lvl[i];
      assign prv = pin_q[i];
      always_comb begin
        case (m)
          SNS_RISE: act = cur & ~prv;
          SNS_FALL: act = ~cur & prv;
          SNS_HIGH: act = cur;
          SNS_LOW:  act = ~cur;
          SNS_BOTH: act = cur ^ prv;
          default:  act = 1'b0;
        endcase
      end
      assign hit[i] = det_en[i] & act;
    end
  endgenerate
endmodule

// File: rtl/gis_pend_mask.sv
`timescale 1ns/1ps
// Pending, unmask and detect-enable state (R6, R7, R8).
module gis_pend_mask #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] wbits,
  input  logic             en_we,
  input  logic             unmask_we,
  input  logic             mask_we,
  input  logic             clr_we,
  input  logic [NPINS-1:0] hit,
  output logic [NPINS-1:0] pend,
  output logic [NPINS-1:0] unmask,
  output logic [NPINS-1:0] det_en
);
  logic [NPINS-1:0] clr_bits;
  assign clr_bits = clr_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      unmask <= '0;
      det_en <= '0;
    end else begin
      // a same-cycle event outranks the clear
      pend <= (pend & ~clr_bits) | hit;
      if (en_we)
        det_en <= wbits;
      if (unmask_we)
        unmask <= unmask | wbits;
      else if (mask_we)
        unmask <= unmask & ~wbits;
    end
  end
endmodule

// File: rtl/gpio_irq_sense.sv
`timescale 1ns/1ps
module gpio_irq_sense #(
  parameter int NPINS   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int FIELD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  import gis_pkg::*;

  localparam int PER_REG = DATA_W / FIELD_W;
  localparam int NREG    = (NPINS + PER_REG - 1) / PER_REG;
  localparam int HALF    = NPINS / 2;

  logic [NPINS*FIELD_W-1:0] fields;
  logic [NPINS*MODE_W-1:0]  modes;
  logic [NPINS-1:0]         wbits, hit, pend_raw, unmask, det_en, masked;
  logic                     en_we, unmask_we, mask_we, clr_we;
  logic [DATA_W-1:0]        rd_next;

  assign wbits     = reg_wdata[NPINS-1:0];
  assign en_we     = reg_wen && reg_addr == ADDR_W'(OFS_DET_EN);
  assign unmask_we = reg_wen && reg_addr == ADDR_W'(OFS_UNMASK);
  assign mask_we   = reg_wen && reg_addr == ADDR_W'(OFS_MASK);
  assign clr_we    = reg_wen && reg_addr == ADDR_W'(OFS_CLEAR);

  gis_sense_cfg #(
    .NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .fields(fields)
  );

  // low bits select the mode; the top flag bit is storage only
  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_mode
      assign modes[i*MODE_W +: MODE_W] = fields[i*FIELD_W +: MODE_W];
    end
  endgenerate

  gis_edge_level #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .modes(modes),
    .det_en(det_en), .hit(hit)
  );

  gis_pend_mask #(.NPINS(NPINS)) u_pend (
    .clk(clk), .rst(rst), .wbits(wbits), .en_we(en_we),
    .unmask_we(unmask_we), .mask_we(mask_we), .clr_we(clr_we),
    .hit(hit), .pend(pend_raw), .unmask(unmask), .det_en(det_en)
  );

  assign masked = pend_raw & unmask;

  always_comb begin
    rd_next = '0;
    if (reg_addr == ADDR_W'(OFS_DET_EN))
      rd_next[NPINS-1:0] = det_en;
    else if (reg_addr == ADDR_W'(OFS_UNMASK))
      rd_next[NPINS-1:0] = unmask;
    else if (reg_addr == ADDR_W'(OFS_RAW))
      rd_next[NPINS-1:0] = pend_raw;
    else if (reg_addr == ADDR_W'(OFS_MASKED))
      rd_next[NPINS-1:0] = masked;
    else begin
      for (int r = 0; r < NREG; r++) begin
        if (reg_addr == ADDR_W'(int'(OFS_SENSE0) + 4 * r))
          rd_next = fields[r*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_lo    <= 1'b0;
      irq_hi    <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      irq_lo    <= |masked[HALF-1:0];
      irq_hi    <= |masked[NPINS-1:HALF];
    end
  end
endmodule

// File: rtl/gpio_irq_sense_chk.sv
`timescale 1ns/1ps
module gpio_irq_sense_chk #(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wen,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [NPINS-1:0]  hit,
  input logic [NPINS-1:0]  pend,
  input logic [NPINS-1:0]  unmask,
  input logic [NPINS-1:0]  det_en,
  input logic              irq_lo,
  input logic              irq_hi
);
  localparam int HALF = NPINS / 2;

  p_irq_lo_r10: assert property (@(posedge clk) disable iff (rst)
    irq_lo == $past(|(pend[HALF-1:0] & unmask[HALF-1:0])));

  p_irq_hi_r10: assert property (@(posedge clk) disable iff (rst)
    irq_hi == $past(|(pend[NPINS-1:HALF] & unmask[NPINS-1:HALF])));

  p_enable_rw_r6: assert property (@(posedge clk) disable iff (rst)
    (wen && addr == ADDR_W'(gis_pkg::OFS_DET_EN)) |=> det_en == $past(wdata[NPINS-1:0]));

  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & ~$past(det_en)) == '0);

  p_unmask_set_r8: assert property (@(posedge clk) disable iff (rst)
    (wen && addr == ADDR_W'(gis_pkg::OFS_UNMASK))
      |=> (unmask & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0]));

  p_mask_set_r8: assert property (@(posedge clk) disable iff (rst)
    (wen && addr == ADDR_W'(gis_pkg::OFS_MASK))
      |=> (unmask & $past(wdata[NPINS-1:0])) == '0);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (wen && addr == ADDR_W'(gis_pkg::OFS_CLEAR))
      |=> (pend & $past(wdata[NPINS-1:0]) & ~$past(hit)) == '0);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> (pend & $past(hit)) == $past(hit));
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(
  .NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
  .hit(hit), .pend(pend_raw), .unmask(unmask), .det_en(det_en),
  .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/tb_gpio_irq_sense.sv
`timescale 1ns/1ps
module tb_gpio_irq_sense;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_lvl = '0;
  logic        reg_wen = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_sense dut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // op: 0 write, 1 drive pins, 2 read and compare
  localparam logic [1:0] OP_WR = 2'd0, OP_PIN = 2'd1, OP_RD = 2'd2;
  localparam int NV = 44;
  // {op, requirement number, address, data, expected}
  localparam logic [77:0] VEC [NV] = '{
    {OP_RD,  4'd1,  8'h20, 32'h0,         32'h0},          // R1 raw empty
    {OP_RD,  4'd1,  8'h14, 32'h0,         32'h0},          // R1 disabled
    {OP_RD,  4'd1,  8'h18, 32'h0,         32'h0},          // R1 masked
    {OP_WR,  4'd2,  8'h40, 32'h0000_4310, 32'h0},          // R2 p0 rise p1 fall p2 low p3 both
    {OP_WR,  4'd6,  8'h14, 32'h0000_000F, 32'h0},
    {OP_RD,  4'd6,  8'h14, 32'h0,         32'h0000_000F},  // R6 readback
    {OP_RD,  4'd5,  8'h20, 32'h0,         32'h0000_0004},  // R5 level low active
    {OP_PIN, 4'd3,  8'h00, 32'h0000_0001, 32'h0},
    {OP_RD,  4'd3,  8'h20, 32'h0,         32'h0000_0005},  // R3 rising
    {OP_RD,  4'd9,  8'h24, 32'h0,         32'h0},          // R9 all masked
    {OP_WR,  4'd8,  8'h18, 32'h0000_0001, 32'h0},
    {OP_RD,  4'd9,  8'h24, 32'h0,         32'h0000_0001},  // R9 masked view
    {OP_WR,  4'd7,  8'h28, 32'h0000_0001, 32'h0},
    {OP_RD,  4'd3,  8'h20, 32'h0,         32'h0000_0004},  // R3 held high no re-set
    {OP_WR,  4'd5,  8'h28, 32'h0000_0004, 32'h0},
    {OP_RD,  4'd5,  8'h20, 32'h0,         32'h0000_0004},  // R5 clear does not stick
    {OP_PIN, 4'd4,  8'h00, 32'h0000_000D, 32'h0},
    {OP_WR,  4'd7,  8'h28, 32'h0000_0004, 32'h0},
    {OP_RD,  4'd4,  8'h20, 32'h0,         32'h0000_0008},  // R4 rise in both mode
    {OP_WR,  4'd7,  8'h28, 32'h0000_0008, 32'h0},
    {OP_RD,  4'd7,  8'h20, 32'h0,         32'h0},          // R7 w1c
    {OP_PIN, 4'd4,  8'h00, 32'h0000_0005, 32'h0},
    {OP_RD,  4'd4,  8'h20, 32'h0,         32'h0000_0008},  // R4 fall in both mode
    {OP_PIN, 4'd3,  8'h00, 32'h0000_0007, 32'h0},
    {OP_RD,  4'd3,  8'h20, 32'h0,         32'h0000_0008},  // R3 fall mode ignores rise
    {OP_PIN, 4'd3,  8'h00, 32'h0000_0005, 32'h0},
    {OP_RD,  4'd3,  8'h20, 32'h0,         32'h0000_000A},  // R3 falling
    {OP_PIN, 4'd6,  8'h00, 32'h0000_0015, 32'h0},
    {OP_RD,  4'd6,  8'h20, 32'h0,         32'h0000_000A},  // R6 disabled pin4 quiet
    {OP_WR,  4'd8,  8'h18, 32'h0000_000A, 32'h0},
    {OP_RD,  4'd9,  8'h24, 32'h0,         32'h0000_000A},
    {OP_WR,  4'd8,  8'h1C, 32'h0000_0002, 32'h0},
    {OP_RD,  4'd8,  8'h24, 32'h0,         32'h0000_0008},  // R8 mask strobe
    {OP_RD,  4'd8,  8'h18, 32'h0,         32'h0000_0009},  // R8 unmask state
    {OP_RD,  4'd11, 8'h1C, 32'h0,         32'h0},          // R11 unmapped
    {OP_RD,  4'd2,  8'h40, 32'h0,         32'h0000_4310},  // R2 readback
    {OP_WR,  4'd2,  8'h4C, 32'hA000_0000, 32'h0},          // pin31: flag + level high
    {OP_RD,  4'd2,  8'h4C, 32'h0,         32'hA000_0000},
    {OP_WR,  4'd2,  8'h40, 32'h0050_4310, 32'h0},          // pin5 code 5
    {OP_WR,  4'd6,  8'h14, 32'h8000_002F, 32'h0},
    {OP_WR,  4'd8,  8'h18, 32'h8000_0000, 32'h0},
    {OP_PIN, 4'd2,  8'h00, 32'h8000_0035, 32'h0},
    {OP_RD,  4'd2,  8'h20, 32'h0,         32'h8000_000A},  // R2 code 5 idle, flagged high works
    {OP_RD,  4'd9,  8'h24, 32'h0,         32'h8000_0008}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic do_pin(input logic [31:0] v);
    @(negedge clk);
    pin_lvl = v;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state at the ports
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [77:0] v;
      v = VEC[k];
      case (v[77:76])
        OP_WR:  do_wr(v[71:64], v[63:32]);
        OP_PIN: do_pin(v[63:32]);
        default: begin
          do_rd(v[71:64], rd);
          chk($sformatf("R%0d vector %0d", v[75:72], k), rd, v[31:0]);
        end
      endcase
    end

    // R10 both requests high with masked 0x8000_0008
    @(negedge clk);
    chk("R10 both lines", {30'h0, irq_hi, irq_lo}, 32'h3);
    do_wr(8'h28, 32'h0000_0008);
    @(negedge clk);
    chk("R10 low line drops", {30'h0, irq_hi, irq_lo}, 32'h2);
    do_pin(32'h0000_0035);
    do_wr(8'h28, 32'h8000_0000);
    @(negedge clk);
    chk("R10 high line drops", {30'h0, irq_hi, irq_lo}, 32'h0);
    // R10 one-cycle latency: pin31 high at negedge, pend at next edge, irq the edge after
    @(negedge clk);
    pin_lvl = 32'h8000_0035;
    @(negedge clk);
    chk("R10 not yet", {31'h0, irq_hi}, 32'h0);
    @(negedge clk);
    chk("R10 registered", {31'h0, irq_hi}, 32'h1);

    // R7 set wins: pin3 rises (both mode) in the cycle its clear is written
    @(negedge clk);
    pin_lvl = 32'h8000_003D;
    reg_wen = 1'b1; reg_addr = 8'h28; reg_wdata = 32'h0000_0008;
    @(negedge clk);
    reg_wen = 1'b0;
    do_rd(8'h20, rd);
    chk("R7 set wins", rd & 32'h0000_0008, 32'h0000_0008);

    // R11 registered read: address changes, data follows one edge later
    @(negedge clk);
    reg_addr = 8'h14;
    @(negedge clk);
    reg_addr = 8'h30;
    chk("R11 first edge", reg_rdata, 32'h8000_002F);
    @(negedge clk);
    chk("R11 unmapped", reg_rdata, 32'h0);

    // R1 mid-run reset
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    pin_lvl = '0;
    chk("R1 irq after reset", {30'h0, irq_hi, irq_lo}, 32'h0);
    do_rd(8'h20, rd); chk("R1 pending", rd, 32'h0);
    do_rd(8'h14, rd); chk("R1 enable", rd, 32'h0);
    do_rd(8'h18, rd); chk("R1 unmask", rd, 32'h0);
    do_rd(8'h40, rd); chk("R1 sense0", rd, 32'h0);
    do_rd(8'h4C, rd); chk("R1 sense3", rd, 32'h0);

    finish_run();
  end
endmodule